// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Bytes are pushed into a transmit buffer. The buffer is either a 16-entry FIFO or, with buffering switched off, a one-entry holding register. When the transmitter is idle, permitted to start and the buffer holds a byte, the block takes the oldest byte. It builds the complete frame from the line-control inputs: data width, parity mode and stop count. It then shifts the frame out at one bit per 16 baud ticks. The baud tick comes from a divisor outside the block and runs at 16 times the bit rate.

The line-control inputs are sampled when a character is loaded, so a character already on the wire is never disturbed by later changes. A break request holds the line low once the character in flight has ended. Clear-to-send flow control, the transmit enable and the global enable all gate only the start of a new character. Clearing any of them mid-frame lets that frame finish.

Top module: `serial_tx`

## Requirements
- R1: After reset the line is high, busy is 0, buf_empty is 1 and buf_full is 0.
- R2: A frame is one low start bit, then the data bits least significant first, then the stop bits (high). The width code `word_len` selects 5 data bits for 00, 6 for 01, 7 for 10 and 8 for 11. Each bit lasts 16 baud ticks, and the line rests high between frames.
- R3: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. It makes the total count of ones in the data plus parity odd when `par_even`=0 and even when `par_even`=1. With `par_en`=0 there is no parity bit, and `par_even` and `par_stick` have no effect.
- R4: With `par_en`=1 and `par_stick`=1, the parity bit is a constant 1 when `par_even`=0 and a constant 0 when `par_even`=1.
- R5: `two_stop`=1 sends two stop bits instead of one.
- R6: While `brk_req` is 1, the line is driven low as soon as no character is in flight, and no new character starts.
- R7: A new character starts only while `glob_en` and `tx_en` are both 1. Clearing either during a frame lets that frame complete.
- R8: With `cts_flow_en`=1, a new character starts only while `cts` is 1.
- R9: `busy` is 1 whenever the buffer is non-empty, even with the transmitter disabled, or a frame is still in flight up to the end of its last stop bit.
- R10: `buf_empty` reflects the buffer only, not the shifter. With `buf_mode`=0 the buffer holds one byte and `buf_full` rises after a single push.
- R11: With `buf_mode`=1 the buffer holds 16 bytes. A push while `buf_full` is 1 is dropped, so exactly 16 characters are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Byte to enqueue |
| wr_push | input | 1 | Enqueue strobe, one byte per cycle |
| buf_mode | input | 1 | 1 = 16-entry FIFO, 0 = one-entry holding register |
| word_len | input | 2 | Data width code (00=5 … 11=8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Parity sense (0 odd, 1 even) |
| par_stick | input | 1 | Constant parity bit select |
| two_stop | input | 1 | Two stop bits |
| brk_req | input | 1 | Break request, line held low when idle |
| glob_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| cts | input | 1 | Clear to send, active high |
| cts_flow_en | input | 1 | Gate character starts on cts |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial line |
| busy | output | 1 | Buffer non-empty or frame in flight |
| buf_empty | output | 1 | Buffer holds no byte |
| buf_full | output | 1 | Buffer at capacity |

## Verification
The assertions check several cycle-local rules on every cycle. Each frame opens with a low line. The line stays low under break when idle. A frame starts only with clear-to-send satisfied, and busy covers a frame in flight. The buffer count never exceeds its capacity, and a push into a full buffer leaves the count unchanged. Other properties span whole frames and can only be shown by the bench's scenarios against its bit-queue model: the bit order and width, the parity values for each mode, the two-stop length, completion after a mid-frame disable, and the exact number of characters that survive an overfill.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } line_cfg_t;

  function automatic int data_bits(input logic [1:0] wlen);
    return 5 + int'(wlen);
  endfunction

  function automatic logic parity_bit(input logic [DATA_W-1:0] d, input line_cfg_t c);
    logic [DATA_W-1:0] mask;
    logic              ones_odd;
    mask     = {DATA_W{1'b1}} >> (3 - int'(c.wlen));
    ones_odd = ^(d & mask);
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? ones_odd : ~ones_odd;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input line_cfg_t c);
    return LEN_W'(2 + data_bits(c.wlen) + int'(c.par_en) + int'(c.two_stop));
  endfunction

  // Bit 0 is sent first; unused upper positions stay at the idle level.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input line_cfg_t c);
    logic [FRAME_W-1:0] f;
    int nd;
    nd   = data_bits(c.wlen);
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nd) f[1+i] = d[i];
    if (c.par_en) f[1+nd] = parity_bit(d, c);
    return f;
  endfunction

endpackage

// File: rtl/serial_tx_buf.sv
module serial_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          one_deep,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = one_deep ? !empty : (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_push_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> count == $past(count));

  assert_one_deep_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (one_deep && !empty && !pop) |=> count == $past(count));

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int LEN_W   = 4,
  parameter int TICKS   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               brk,
  output logic               txd,
  output logic               active
);
  localparam int TW = $clog2(TICKS);

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;
  logic [TW-1:0]      tcnt;
  logic               bit_end;

  assign bit_end = active && tick && (tcnt == TW'(TICKS-1));
  assign txd     = active ? shreg[0] : !brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      tcnt      <= '0;
      active    <= 1'b0;
    end else if (load && !active) begin
      shreg     <= frame;
      bits_left <= len - 1'b1;
      tcnt      <= '0;
      active    <= 1'b1;
    end else if (active && tick) begin
      if (bit_end) begin
        tcnt <= '0;
        if (bits_left == '0) begin
          active <= 1'b0;
        end else begin
          shreg     <= {1'b1, shreg[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !txd);

  assert_break_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && brk) |-> !txd);

  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(bit_end)) |-> $stable(txd) || $past(brk) != brk);

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BIT_TICKS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_push,
  input  logic       buf_mode,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       two_stop,
  input  logic       brk_req,
  input  logic       glob_en,
  input  logic       tx_en,
  input  logic       cts,
  input  logic       cts_flow_en,
  input  logic       baud_tick,
  output logic       txd,
  output logic       busy,
  output logic       buf_empty,
  output logic       buf_full
);
  line_cfg_t          cfg;
  logic [DATA_W-1:0]  head;
  logic               tx_active;
  logic               start_ok;
  logic               cts_ok;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   flen;

  assign cfg    = '{wlen: word_len, par_en: par_en, par_even: par_even,
                    par_stick: par_stick, two_stop: two_stop};
  assign cts_ok = !cts_flow_en || cts;
  assign start_ok = !tx_active && !buf_empty && baud_tick && glob_en && tx_en
                    && cts_ok && !brk_req;
  assign frame  = build_frame(head, cfg);
  assign flen   = frame_len(cfg);
  assign busy   = !buf_empty || tx_active;

  serial_tx_buf #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .one_deep(!buf_mode),
    .push(wr_push), .din(wr_data), .pop(start_ok),
    .dout(head), .empty(buf_empty), .full(buf_full)
  );

  serial_tx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .TICKS(BIT_TICKS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(start_ok),
    .frame(frame), .len(flen), .brk(brk_req),
    .txd(txd), .active(tx_active)
  );

  assert_busy_covers_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> busy);

  assert_start_needs_cts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(cts_ok));

  assert_start_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(glob_en && tx_en));

  assert_empty_not_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !buf_full);

endmodule

// File: tb/tb_serial_tx.sv
module tb_serial_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] wr_data = 0;
  logic wr_push = 0, buf_mode = 1;
  logic [1:0] word_len = 2'b11;
  logic par_en = 0, par_even = 0, par_stick = 0, two_stop = 0, brk_req = 0;
  logic glob_en = 1, tx_en = 1, cts = 1, cts_flow_en = 0, baud_tick = 0;
  logic txd, busy, buf_empty, buf_full;

  int compared = 0, mismatched = 0;
  string cur_req = "R2";

  serial_tx dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: a byte queue and a queue of pending line bits.
  byte unsigned mq[$];
  bit mbits[$];
  bit mact = 0, full_pre;
  int mt = 0;

  function automatic void make_bits(input byte unsigned d);
    int n, ones;
    bit p;
    n = 5 + word_len;
    ones = 0;
    mbits.delete();
    mbits.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      mbits.push_back(d[i]);
      ones += d[i];
    end
    if (par_en) begin
      if (par_stick) p = !par_even;
      else           p = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
      mbits.push_back(p);
    end
    mbits.push_back(1'b1);
    if (two_stop) mbits.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mbits.delete(); mact = 0; mt = 0;
    end else begin
      full_pre = mq.size() >= (buf_mode ? 16 : 1);
      if (mact) begin
        if (baud_tick) begin
          mt++;
          if (mt == 16) begin
            mt = 0;
            void'(mbits.pop_front());
            if (mbits.size() == 0) mact = 0;
          end
        end
      end else if (baud_tick && mq.size() > 0 && glob_en && tx_en
                   && (!cts_flow_en || cts) && !brk_req) begin
        make_bits(mq.pop_front());
        mact = 1; mt = 0;
      end
      if (wr_push && !full_pre) mq.push_back(wr_data);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit et;
      et = mact ? mbits[0] : !brk_req;
      check(txd == et && busy == (mq.size() > 0 || mact) &&
            buf_empty == (mq.size() == 0) &&
            buf_full == (mq.size() >= (buf_mode ? 16 : 1)),
            "outputs{txd,busy,empty,full}",
            {txd, busy, buf_empty, buf_full},
            {et, (mq.size() > 0 || mact), (mq.size() == 0), (mq.size() >= (buf_mode ? 16 : 1))});
    end
  end

  // Baud tick every other cycle, changed just after the edge.
  initial forever begin
    @(posedge clk); #1 baud_tick = ~baud_tick;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input byte unsigned d);
    @(posedge clk); #1;
    wr_data = d; wr_push = 1;
    @(posedge clk); #1;
    wr_push = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && (busy || mact); i++) step(1);
    step(4);
  endtask

  task automatic set_cfg(input logic [1:0] w, input bit pe, input bit ev,
                         input bit st, input bit ts);
    @(posedge clk); #1;
    word_len = w; par_en = pe; par_even = ev; par_stick = st; two_stop = ts;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check(txd == 1 && busy == 0 && buf_empty == 1 && buf_full == 0, "reset state",
          {txd, busy, buf_empty, buf_full}, 4'b1010);

    cur_req = "R2";
    set_cfg(2'b11, 0, 0, 0, 0);
    push(8'hA5); push(8'h3C); wait_idle();
    set_cfg(2'b01, 0, 0, 0, 0);
    push(8'hD6); wait_idle();

    cur_req = "R3";
    set_cfg(2'b00, 1, 0, 0, 0); push(8'hFF); wait_idle();
    set_cfg(2'b10, 1, 1, 0, 0); push(8'h55); push(8'h01); wait_idle();
    set_cfg(2'b11, 0, 1, 1, 0); push(8'h81); wait_idle();

    cur_req = "R4";
    set_cfg(2'b11, 1, 0, 1, 0); push(8'h00); wait_idle();
    set_cfg(2'b11, 1, 1, 1, 0); push(8'hFF); wait_idle();

    cur_req = "R5";
    set_cfg(2'b11, 1, 1, 0, 1); push(8'h96); push(8'h69); wait_idle();

    cur_req = "R6";
    set_cfg(2'b11, 0, 0, 0, 0);
    push(8'hF0); step(60); brk_req = 1;
    wait_idle();
    @(negedge clk);
    check(txd == 0, "break holds line low", txd, 0);
    push(8'h12); step(200);
    @(negedge clk);
    check(buf_empty == 0 && busy == 1, "no start under break", {buf_empty, busy}, 2'b01);
    step(1); brk_req = 0; wait_idle();

    cur_req = "R9";
    glob_en = 0;
    push(8'h33);
    @(negedge clk);
    check(busy == 1 && txd == 1, "busy while disabled", {busy, txd}, 2'b11);

    cur_req = "R7";
    step(100);
    @(negedge clk);
    check(buf_empty == 0, "disabled holds byte", buf_empty, 0);
    step(1); glob_en = 1; push(8'h44);
    step(150); tx_en = 0;
    step(700);
    @(negedge clk);
    check(buf_empty == 0 && busy == 1, "second byte waits after tx_en low",
          {buf_empty, busy}, 2'b01);
    step(1); tx_en = 1; wait_idle();

    cur_req = "R8";
    cts_flow_en = 1; cts = 0;
    push(8'h5A); step(200);
    @(negedge clk);
    check(buf_empty == 0, "held by cts", buf_empty, 0);
    step(1); cts = 1; wait_idle();
    cts_flow_en = 0;

    cur_req = "R10";
    buf_mode = 0; glob_en = 0;
    push(8'hC3);
    @(negedge clk);
    check(buf_full == 1 && buf_empty == 0, "one-deep full", {buf_full, buf_empty}, 2'b10);
    push(8'h3C);
    step(1); glob_en = 1; wait_idle();

    cur_req = "R11";
    buf_mode = 1; glob_en = 0;
    for (int i = 0; i < 17; i++) push(8'(i * 7 + 1));
    @(negedge clk);
    check(buf_full == 1, "sixteen entries fill", buf_full, 1);
    step(1); glob_en = 1; wait_idle();
    @(negedge clk);
    check(buf_empty == 1 && busy == 0, "drained", {buf_empty, busy}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule